// File: doc/BRIEF.md
# Virtual Page Number and Page Table Hash Generator

This block takes a virtual segment identifier and an effective address, forms the virtual page number (the virtual address with its 12 offset bits dropped), and folds that page number into a 39-bit page table hash. It is meant to sit in front of a hashed page table walker. The walker masks the hash down to a group index and handles the secondary hash itself.

Two segment sizes are supported: 256 MB and 1 TB. Each uses its own fold. For 256 MB segments, the part of the page number above the segment index is combined with the page index. For 1 TB segments, the segment part is first mixed with a copy of itself moved up by 25 bits. In both cases the page index is scaled down by the page size, which is given as a page shift of 12, 16 or 24.

Results are registered one cycle after a qualified request. Any other page shift raises an error flag for that result.

Top module: `vpn_hash_gen`

## Requirements
- R1: With `seg_1t_i`=0 (256 MB segment), `vpn_o` equals (`vsid_i` << 16) OR `ea_i[27:12]`, truncated to 64 bits.
- R2: With `seg_1t_i`=1 (1 TB segment), `vpn_o` equals (`vsid_i` << 28) OR `ea_i[39:12]`, truncated to 64 bits.
- R3: With a 256 MB segment and a legal page shift, `hash_o` equals the low 39 bits of (vpn >> 16) XOR (vpn[15:0] >> (shift − 12)).
- R4: With a 1 TB segment and a legal page shift, let s = vpn >> 28. `hash_o` equals the low 39 bits of s XOR (s << 25) XOR (vpn[27:0] >> (shift − 12)).
- R5: `pshift_i` is the page shift in binary. The values 12, 16 and 24 move the page index right by 0, 4 and 12 bits.
- R6: Any other `pshift_i` value with `valid_i` high gives `err_o`=1 and `hash_o`=0 in the result cycle. `vpn_o` is still formed as in R1/R2. A legal shift gives `err_o`=0.
- R7: `valid_o` equals `valid_i` delayed by exactly one clock.
- R8: While `valid_i` is low, `vpn_o` and `hash_o` keep their previous values.
- R9: While `rst_ni` is low, `valid_o`, `err_o`, `vpn_o` and `hash_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request qualifier |
| vsid_i | input | 52 | Virtual segment identifier |
| ea_i | input | 64 | Effective address |
| seg_1t_i | input | 1 | 1 selects 1 TB segments, 0 selects 256 MB |
| pshift_i | input | 6 | Page shift (12, 16 or 24) |
| valid_o | output | 1 | Result valid |
| vpn_o | output | 64 | Virtual page number |
| hash_o | output | 39 | Page table hash |
| err_o | output | 1 | Illegal page shift for this result |

## Verification
The pipeline holds only one stage of state, so any wrong internal value shows up at the ports on the cycle right after the request that caused it. A wrong shift decode corrupts only the low bits of the hash. A lost 1 TB self-mix shows in bits 25 and up. An error flag that leaks into the next result flips `err_o` and zeroes `hash_o` on a legal request. Random traffic across both segment sizes, all legal shifts and illegal shifts is compared against bench functions, together with directed all-ones, zero and hold cases.

// File: rtl/vhg_pkg.sv
package vhg_pkg;
  localparam int unsigned PAGE_SHIFT    = 12;
  localparam int unsigned SEG_SHIFT_S   = 28;  // 256 MB
  localparam int unsigned SEG_SHIFT_L   = 40;  // 1 TB
  localparam int unsigned MIX_SHIFT_L   = 25;
  localparam int unsigned IDX_W_S       = SEG_SHIFT_S - PAGE_SHIFT;
  localparam int unsigned IDX_W_L       = SEG_SHIFT_L - PAGE_SHIFT;
  localparam int unsigned PS_W          = 6;
  localparam int unsigned SH_W          = 4;
  localparam int unsigned N_LEGAL       = 3;
  localparam int unsigned LEGAL_PS [N_LEGAL] = '{12, 16, 24};

  typedef enum logic {SEG_256M = 1'b0, SEG_1T = 1'b1} seg_e;
endpackage

// File: rtl/vhg_vpn_build.sv
module vhg_vpn_build
  import vhg_pkg::*;
#(
  parameter int unsigned VSID_W = 52,
  parameter int unsigned EA_W   = 64,
  parameter int unsigned VPN_W  = 64
) (
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [EA_W-1:0]   ea_i,
  input  seg_e              seg_i,
  output logic [VPN_W-1:0]  vpn_o
);
  logic [VPN_W-1:0] vsid_ext;
  logic [VPN_W-1:0] idx_s, idx_l;
  logic             unused_ea;

  assign vsid_ext  = VPN_W'(vsid_i);
  assign idx_s     = VPN_W'(ea_i[SEG_SHIFT_S-1:PAGE_SHIFT]);
  assign idx_l     = VPN_W'(ea_i[SEG_SHIFT_L-1:PAGE_SHIFT]);
  assign unused_ea = ^{ea_i[EA_W-1:SEG_SHIFT_L], ea_i[PAGE_SHIFT-1:0]};

  always_comb begin
    if (seg_i == SEG_1T) vpn_o = (vsid_ext << IDX_W_L) | idx_l;
    else                 vpn_o = (vsid_ext << IDX_W_S) | idx_s;
  end
endmodule

// File: rtl/vhg_shift_check.sv
module vhg_shift_check
  import vhg_pkg::*;
(
  input  logic [PS_W-1:0] pshift_i,
  output logic [SH_W-1:0] sh_o,
  output logic            bad_o
);
  logic [N_LEGAL-1:0] hit;

  for (genvar g = 0; g < N_LEGAL; g++) begin : g_legal
    assign hit[g] = (pshift_i == PS_W'(LEGAL_PS[g]));
  end

  assign bad_o = ~|hit;
  // Illegal shifts decode to 0; the hash is forced to zero downstream.
  assign sh_o  = bad_o ? '0 : SH_W'(pshift_i - PS_W'(PAGE_SHIFT));
endmodule

// File: rtl/vhg_hash_fold.sv
module vhg_hash_fold
  import vhg_pkg::*;
#(
  parameter int unsigned VPN_W  = 64,
  parameter int unsigned HASH_W = 39
) (
  input  logic [VPN_W-1:0]  vpn_i,
  input  seg_e              seg_i,
  input  logic [SH_W-1:0]   sh_i,
  input  logic              bad_i,
  output logic [HASH_W-1:0] hash_o
);
  logic [VPN_W-1:0] seg_s, seg_l, mix_l;
  logic [VPN_W-1:0] pg_s, pg_l;
  logic [VPN_W-1:0] fold;

  assign seg_s = vpn_i >> IDX_W_S;
  assign seg_l = vpn_i >> IDX_W_L;
  assign mix_l = seg_l ^ (seg_l << MIX_SHIFT_L);
  assign pg_s  = VPN_W'(vpn_i[IDX_W_S-1:0]) >> sh_i;
  assign pg_l  = VPN_W'(vpn_i[IDX_W_L-1:0]) >> sh_i;

  always_comb begin
    if (seg_i == SEG_1T) fold = mix_l ^ pg_l;
    else                 fold = seg_s ^ pg_s;
  end

  assign hash_o = bad_i ? '0 : HASH_W'(fold);
endmodule

// File: rtl/vpn_hash_gen.sv
module vpn_hash_gen
  import vhg_pkg::*;
#(
  parameter int unsigned VSID_W = 52,
  parameter int unsigned EA_W   = 64,
  parameter int unsigned VPN_W  = 64,
  parameter int unsigned HASH_W = 39
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [EA_W-1:0]   ea_i,
  input  logic              seg_1t_i,
  input  logic [PS_W-1:0]   pshift_i,
  output logic              valid_o,
  output logic [VPN_W-1:0]  vpn_o,
  output logic [HASH_W-1:0] hash_o,
  output logic              err_o
);
  seg_e              seg;
  logic [VPN_W-1:0]  vpn_d;
  logic [HASH_W-1:0] hash_d;
  logic [SH_W-1:0]   sh;
  logic              bad;

  assign seg = seg_e'(seg_1t_i);

  vhg_vpn_build #(.VSID_W(VSID_W), .EA_W(EA_W), .VPN_W(VPN_W)) u_vpn (
    .vsid_i(vsid_i), .ea_i(ea_i), .seg_i(seg), .vpn_o(vpn_d)
  );

  vhg_shift_check u_chk (
    .pshift_i(pshift_i), .sh_o(sh), .bad_o(bad)
  );

  vhg_hash_fold #(.VPN_W(VPN_W), .HASH_W(HASH_W)) u_fold (
    .vpn_i(vpn_d), .seg_i(seg), .sh_i(sh), .bad_i(bad), .hash_o(hash_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      vpn_o   <= '0;
      hash_o  <= '0;
    end else begin
      valid_o <= valid_i;
      err_o   <= valid_i & bad;
      if (valid_i) begin
        vpn_o  <= vpn_d;
        hash_o <= hash_d;
      end
    end
  end

  assert_valid_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(vpn_o) && $stable(hash_o)));
  assert_err_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (valid_o && hash_o == '0));
  assert_legal_no_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (pshift_i == PS_W'(12) || pshift_i == PS_W'(16) || pshift_i == PS_W'(24)))
    |=> !err_o);
  assert_no_err_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !err_o);
endmodule

// File: tb/sim_vpn_hash_gen.sv
module sim_vpn_hash_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [51:0] vsid_i = '0;
  logic [63:0] ea_i = '0;
  logic        seg_1t_i = 1'b0;
  logic [5:0]  pshift_i = 6'd12;
  logic        valid_o, err_o;
  logic [63:0] vpn_o;
  logic [38:0] hash_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk_i = ~clk_i;

  vpn_hash_gen u0 (
    .clk_i, .rst_ni, .valid_i, .vsid_i, .ea_i, .seg_1t_i, .pshift_i,
    .valid_o, .vpn_o, .hash_o, .err_o
  );

  function automatic logic [63:0] ref_vpn(logic [51:0] v, logic [63:0] ea, logic l);
    logic [63:0] vv = {12'd0, v};
    if (l) return (vv << 28) | {36'd0, ea[39:12]};
    return (vv << 16) | {48'd0, ea[27:12]};
  endfunction

  function automatic bit legal(logic [5:0] ps);
    return ps == 6'd12 || ps == 6'd16 || ps == 6'd24;
  endfunction

  function automatic logic [38:0] ref_hash(logic [63:0] vpn, logic l, logic [5:0] ps);
    logic [63:0] s, h;
    int unsigned d;
    if (!legal(ps)) return '0;
    d = int'(ps) - 12;
    if (l) begin
      s = vpn >> 28;
      h = s ^ (s << 25) ^ ({36'd0, vpn[27:0]} >> d);
    end else begin
      h = (vpn >> 16) ^ ({48'd0, vpn[15:0]} >> d);
    end
    return h[38:0];
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [51:0] v, logic [63:0] ea, logic l, logic [5:0] ps, string req);
    logic [63:0] ev;
    @(negedge clk_i);
    vsid_i = v; ea_i = ea; seg_1t_i = l; pshift_i = ps; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    ev = ref_vpn(v, ea, l);
    chk({req, " R7 valid"}, {63'd0, valid_o}, 64'd1);
    chk({req, l ? " R2 vpn" : " R1 vpn"}, vpn_o, ev);
    chk({req, l ? " R4 hash" : " R3 hash"}, {25'd0, hash_o}, {25'd0, ref_hash(ev, l, ps)});
    chk({req, " R6 err"}, {63'd0, err_o}, {63'd0, !legal(ps)});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] hv, hh;
    logic [5:0] pss [3];
    pss = '{6'd12, 6'd16, 6'd24};
    void'($urandom(32'h5eed_1234));
    valid_i = 1'b1;
    ea_i = '1; vsid_i = '1;
    repeat (3) @(negedge clk_i);
    chk("R9 reset valid", {63'd0, valid_o}, 64'd0);
    chk("R9 reset vpn", vpn_o, 64'd0);
    chk("R9 reset hash", {25'd0, hash_o}, 64'd0);
    chk("R9 reset err", {63'd0, err_o}, 64'd0);
    valid_i = 1'b0;
    rst_ni = 1'b1;

    // directed corners
    run('0, '0, 1'b0, 6'd12, "zero");
    run('1, '1, 1'b0, 6'd12, "ones s12");
    run('1, '1, 1'b0, 6'd24, "ones s24 R5");
    run('1, '1, 1'b1, 6'd16, "ones l16 R5");
    run(52'h1, 64'h0, 1'b1, 6'd12, "l mix bit R4");
    run(52'h0, 64'h0000_00ff_ffff_f000, 1'b1, 6'd24, "l idx R5");
    run(52'h0, 64'h0000_0000_0fff_f000, 1'b0, 6'd16, "s idx R5");
    run(52'habc, 64'h1234_5678_9abc_def0, 1'b0, 6'd20, "bad ps R6");
    run(52'habc, 64'h1234_5678_9abc_def0, 1'b1, 6'd13, "bad ps l R6");
    run(52'habc, 64'h1234_5678_9abc_def0, 1'b1, 6'd24, "after bad R6");

    // hold while idle
    hv = vpn_o; hh = {25'd0, hash_o};
    @(negedge clk_i);
    vsid_i = 52'h5555; ea_i = 64'hdead_beef_cafe_0000; seg_1t_i = 1'b0;
    pshift_i = 6'd12; valid_i = 1'b0;
    @(negedge clk_i);
    chk("R7 idle valid", {63'd0, valid_o}, 64'd0);
    chk("R8 hold vpn", vpn_o, hv);
    chk("R8 hold hash", {25'd0, hash_o}, hh);
    chk("R6 idle err", {63'd0, err_o}, 64'd0);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      logic [51:0] rv;
      logic [63:0] re;
      logic [5:0]  rp;
      rv = {$urandom, $urandom};
      re = {$urandom, $urandom};
      rp = ($urandom % 10 == 0) ? 6'($urandom) : pss[$urandom % 3];
      run(rv, re, 1'($urandom), rp, "rand");
    end

    // back-to-back pipeline
    @(negedge clk_i);
    vsid_i = 52'h77; ea_i = 64'h0000_0123_4567_8000; seg_1t_i = 1'b1;
    pshift_i = 6'd16; valid_i = 1'b1;
    @(negedge clk_i);
    chk("b2b R2 vpn0", vpn_o, ref_vpn(52'h77, 64'h0000_0123_4567_8000, 1'b1));
    vsid_i = 52'h99; seg_1t_i = 1'b0; pshift_i = 6'd24;
    @(negedge clk_i);
    valid_i = 1'b0;
    hv = ref_vpn(52'h99, 64'h0000_0123_4567_8000, 1'b0);
    chk("b2b R7 valid1", {63'd0, valid_o}, 64'd1);
    chk("b2b R1 vpn1", vpn_o, hv);
    chk("b2b R3 hash1", {25'd0, hash_o}, {25'd0, ref_hash(hv, 1'b0, 6'd24)});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule